// File: doc/BRIEF.md
# Serial Configuration Bitstream Streamer

This block is the controller of a serial configuration memory. It holds a fixed bitstream in a small on-chip image and sends it to a programmable logic device one bit for each rising edge of a serial clock. An internal address counter selects the bit that is on the data pin. The counter moves only while three conditions all hold: the combined enable/reset line is high, chip select is low, and the stream is not yet finished.

The block runs as a clock master or as a clock follower. As a master, a divide-by-two oscillator from the system clock drives the serial clock pin. As a follower, the pin is an input from the upstream device, which is synchronised and edge-detected. Pulling the enable/reset line low restarts the stream from the first bit. Once the whole stream has been sent, both pins go to fixed idle states. The serial clock is held low. A build parameter selects whether the data pin is then driven high or released.

Top module: `cfg_bit_streamer`

## Requirements
- R1: Stream bit k is bit (k mod 8) of stored byte floor(k/8), so each byte goes out least significant bit first. Exactly NBITS bits are sent, one on each rising serial clock edge.
- R2: The bit on the data pin does not change in the system clock cycle in which a rising serial clock edge is seen. It changes at the earliest one system clock later.
- R3: The address counter holds its value whenever chip select is high or the stream is done. Clock edges received in those states are lost, and the stream resumes at the same bit.
- R4: While the enable/reset line `oe` is low, the counter and `done` are cleared within one clock. Raising `oe` again restarts the stream at bit 0.
- R5: While `oe` is low, the serial clock pin is driven (`sclk_oe`=1) and low (`sclk_out`=0) in both modes.
- R6: While `done` is 1, the serial clock pin is driven low in both modes.
- R7: The data pin is released (`data_oe`=0) whenever chip select is high or `oe` is low.
- R8: After completion with chip select low, PARK_HIGH=1 drives the data pin with `data_oe`=1 and `data_out`=1. PARK_HIGH=0 releases it (`data_oe`=0).
- R9: `done` rises when the counter reaches NBITS and stays set until `oe` goes low. The counter never passes NBITS.
- R10: In follower mode (MASTER=0), the clock pin is released (`sclk_oe`=0) while streaming. Each rising edge of `sclk_in` advances the stream within three system clocks.
- R11: In master mode, while `oe` is high and the stream is not done, `sclk_out` toggles on every system clock. Its rising edges are therefore two clocks apart, whatever the state of chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; source of the oscillator and of all registers |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| oe | input | 1 | Output enable when high; holds the stream at its start when low |
| cs_n | input | 1 | Chip select, active low |
| sclk_in | input | 1 | Serial clock from the upstream device (follower mode) |
| sclk_out | output | 1 | Serial clock value driven on the clock pin |
| sclk_oe | output | 1 | Clock pin driver enable |
| data_out | output | 1 | Serial data value |
| data_oe | output | 1 | Data pin driver enable |
| done | output | 1 | Whole bitstream has been sent |

## Verification
A counter that skips or repeats a bit puts a wrong bit on the data pin. The receiver model sees it at the next rising serial clock edge, which is two system clocks away in master mode and about three in follower mode. If the three-way gate leaks, a bit is lost during a chip-select pause, and the compare fails at the first edge after the pause ends. If the done state is wrong, the stream ends early or late, or the clock and data pins fail to reach their idle levels. Both show up in the first few cycles after the last bit.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

  // Byte row of the stored image that holds stream bit idx.
  function automatic int unsigned byte_of(input int unsigned idx);
    return idx >> 3;
  endfunction

  // Bit lane inside that byte; low lanes leave first.
  function automatic logic [2:0] lane_of(input int unsigned idx);
    return idx[2:0];
  endfunction

  // Counter width able to hold the values 0 .. nbits.
  function automatic int unsigned idx_width(input int unsigned nbits);
    return $clog2(nbits + 1);
  endfunction

endpackage

// File: rtl/cfg_clk_source.sv
module cfg_clk_source #(
  parameter bit MASTER = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sclk_in,
  output logic osc,
  output logic pin_rise
);
  logic osc_q;
  logic sync1_q, sync2_q;
  logic pin_prev_q;
  logic pin_now;

  // Master: divide-by-two oscillator. Follower: two-flop synchroniser.
  assign pin_now = MASTER ? osc_q : sync2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q      <= 1'b0;
      sync1_q    <= 1'b0;
      sync2_q    <= 1'b0;
      pin_prev_q <= 1'b0;
    end else begin
      osc_q      <= run ? ~osc_q : 1'b0;
      sync1_q    <= sclk_in;
      sync2_q    <= sync1_q;
      pin_prev_q <= pin_now;
    end
  end

  // True in the cycle after the pin-level clock went high, so the bit
  // already sampled downstream is replaced one clock later.
  assign pin_rise = pin_now & ~pin_prev_q;
  assign osc      = osc_q;
endmodule

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr #(
  parameter int unsigned NBITS = 64,
  parameter int unsigned AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          oe,
  input  logic          cs_n,
  input  logic          pin_rise,
  output logic [AW-1:0] addr,
  output logic          done
);
  logic [AW-1:0] addr_q;
  logic          advance;

  assign done    = (addr_q == AW'(NBITS));
  assign advance = pin_rise & oe & ~cs_n & ~done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (!oe)     addr_q <= '0;
    else if (advance) addr_q <= addr_q + AW'(1);
  end

  assign addr = addr_q;
endmodule

// File: rtl/cfg_image_rom.sv
module cfg_image_rom
  import cfg_stream_pkg::*;
#(
  parameter int unsigned          BYTES = 8,
  parameter int unsigned          AW    = 7,
  parameter logic [BYTES*8-1:0]   IMAGE = '0
) (
  input  logic [AW-1:0] idx,
  output logic          bit_o
);
  localparam int unsigned BW = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic [7:0]    mem [BYTES];
  logic [BW-1:0] row;
  logic [2:0]    lane;
  logic          hit;

  for (genvar b = 0; b < BYTES; b++) begin : g_row
    assign mem[b] = IMAGE[8*b +: 8];
  end

  always_comb begin
    row   = BW'(byte_of(32'(idx)));
    lane  = lane_of(32'(idx));
    hit   = byte_of(32'(idx)) < BYTES;
    bit_o = hit ? mem[row][lane] : 1'b0;
  end
endmodule

// File: rtl/cfg_bit_streamer.sv
module cfg_bit_streamer
  import cfg_stream_pkg::*;
#(
  parameter int unsigned        BYTES     = 8,
  parameter int unsigned        NBITS     = BYTES * 8,
  parameter bit                 MASTER    = 1'b1,
  parameter bit                 PARK_HIGH = 1'b1,
  parameter logic [BYTES*8-1:0] IMAGE     = 64'hA5_3C_0F_F0_96_69_81_7E
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oe,
  input  logic cs_n,
  input  logic sclk_in,
  output logic sclk_out,
  output logic sclk_oe,
  output logic data_out,
  output logic data_oe,
  output logic done
);
  localparam int unsigned AW = idx_width(NBITS);

  logic [AW-1:0] addr_q;
  logic          done_q;
  logic          pin_rise;
  logic          osc;
  logic          run;
  logic          rom_bit;

  // Oscillator runs only while enabled and data remains.
  assign run = oe & ~done_q;

  cfg_clk_source #(.MASTER(MASTER)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .sclk_in  (sclk_in),
    .osc      (osc),
    .pin_rise (pin_rise)
  );

  cfg_addr_ctr #(.NBITS(NBITS), .AW(AW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe       (oe),
    .cs_n     (cs_n),
    .pin_rise (pin_rise),
    .addr     (addr_q),
    .done     (done_q)
  );

  cfg_image_rom #(.BYTES(BYTES), .AW(AW), .IMAGE(IMAGE)) u_rom (
    .idx   (addr_q),
    .bit_o (rom_bit)
  );

  // Clock pin: master always drives it; follower drives it low when idle.
  assign sclk_out = MASTER ? (osc & run) : 1'b0;
  assign sclk_oe  = MASTER ? 1'b1 : (~oe | done_q);

  // Data pin: live bit while streaming, parked value after completion.
  assign data_out = done_q ? 1'b1 : rom_bit;
  assign data_oe  = ~cs_n & oe & (~done_q | PARK_HIGH);
  assign done     = done_q;
endmodule

// File: rtl/cfg_bit_streamer_chk.sv
module cfg_bit_streamer_chk #(
  parameter int unsigned NBITS = 64,
  parameter int unsigned AW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          oe,
  input logic          cs_n,
  input logic          sclk_out,
  input logic          sclk_oe,
  input logic          data_out,
  input logic          data_oe,
  input logic          done,
  input logic [AW-1:0] addr,
  input logic          rise_evt
);
  AST_DATA_HELD_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n) (rise_evt && oe && $past(oe)) |-> $stable(data_out)); // R2
  AST_ADDR_FROZEN_GATED: assert property (@(posedge clk) disable iff (!rst_n) (oe && (cs_n || done)) |=> (addr == $past(addr))); // R3
  AST_OE_LOW_CLEARS:     assert property (@(posedge clk) disable iff (!rst_n) !oe |=> (addr == '0 && !done)); // R4
  AST_CLK_LOW_IN_RESET:  assert property (@(posedge clk) disable iff (!rst_n) !oe |-> (sclk_oe && !sclk_out)); // R5
  AST_CLK_PARKED_DONE:   assert property (@(posedge clk) disable iff (!rst_n) done |-> (sclk_oe && !sclk_out)); // R6
  AST_DATA_RELEASED:     assert property (@(posedge clk) disable iff (!rst_n) (cs_n || !oe) |-> !data_oe); // R7
  AST_DONE_STICKY:       assert property (@(posedge clk) disable iff (!rst_n) (done && oe) |=> done); // R9
  AST_ADDR_BOUNDED:      assert property (@(posedge clk) disable iff (!rst_n) addr <= AW'(NBITS)); // R9
endmodule

bind cfg_bit_streamer cfg_bit_streamer_chk #(.NBITS(NBITS), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .oe       (oe),
  .cs_n     (cs_n),
  .sclk_out (sclk_out),
  .sclk_oe  (sclk_oe),
  .data_out (data_out),
  .data_oe  (data_oe),
  .done     (done),
  .addr     (addr_q),
  .rise_evt (pin_rise)
);

// File: tb/tb_cfg_bit_streamer.sv
`timescale 1ns/1ps
module tb_cfg_bit_streamer;
  localparam int          NB_M  = 64;
  localparam logic [63:0] IMG_M = 64'hA5_3C_0F_F0_96_69_81_7E;
  localparam int          NB_S  = 32;
  localparam logic [31:0] IMG_S = 32'hC3_5A_E1_2D;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic oe_m, cs_m, sin_m, sclk_out_m, sclk_oe_m, data_out_m, data_oe_m, done_m;
  logic oe_s, cs_s, sin_s, sclk_out_s, sclk_oe_s, data_out_s, data_oe_s, done_s;

  cfg_bit_streamer #(.BYTES(8), .MASTER(1'b1), .PARK_HIGH(1'b1), .IMAGE(IMG_M)) dut (
    .clk(clk), .rst_n(rst_n), .oe(oe_m), .cs_n(cs_m), .sclk_in(sin_m),
    .sclk_out(sclk_out_m), .sclk_oe(sclk_oe_m), .data_out(data_out_m),
    .data_oe(data_oe_m), .done(done_m));

  cfg_bit_streamer #(.BYTES(4), .MASTER(1'b0), .PARK_HIGH(1'b0), .IMAGE(IMG_S)) dut_slv (
    .clk(clk), .rst_n(rst_n), .oe(oe_s), .cs_n(cs_s), .sclk_in(sin_s),
    .sclk_out(sclk_out_s), .sclk_oe(sclk_oe_s), .data_out(data_out_s),
    .data_oe(data_oe_s), .done(done_s));

  int  n_chk = 0;
  int  n_bad = 0;
  int  cyc   = 0;
  bit  finished = 1'b0;

  // Expected stream bit: pick the byte, then its lane, low lane first.
  function automatic bit exp_bit(input logic [63:0] img, input int k);
    logic [7:0] b;
    b = img[8*(k/8) +: 8];
    return b[k%8];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      wrap_up();
    end
  end

  // Receiver model for the master: samples data at each sclk_out rise.
  task automatic recv_m(input int nmax, input bit pauses, input string req,
                        output int got, output int bad_iv);
    int last;
    bit prev;
    last = -1; prev = sclk_out_m; got = 0; bad_iv = 0;
    while (got < nmax && !done_m) begin
      @(negedge clk);
      if (sclk_out_m && !prev) begin
        if (last >= 0 && cyc - last != 2) bad_iv++;
        last = cyc;
        if (data_oe_m) begin
          check(data_out_m == exp_bit(IMG_M, got), req, $sformatf("bit %0d", got),
                data_out_m, exp_bit(IMG_M, got));
          got++;
        end
      end
      prev = sclk_out_m;
      if (pauses && !sclk_out_m && got > 0 && got < nmax - 2 && ($urandom % 6 == 0)) begin
        cs_m = 1'b1;
        #1;
        check(!data_oe_m, "R7", "data released in pause", data_oe_m, 0);
        repeat (1 + $urandom % 5) @(negedge clk);
        while (sclk_out_m) @(negedge clk);
        cs_m = 1'b0;   // R3: stream must resume at bit 'got'
        prev = sclk_out_m;
        last = -1;
      end
    end
  endtask

  task automatic count_clk_high(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sclk_out_m) highs++;
    end
  endtask

  task automatic pulse_s(input int k, input bit chk_hold);
    sin_s = 1'b1;
    @(negedge clk);
    if (chk_hold)
      check(data_out_s == exp_bit({32'h0, IMG_S}, k), "R2", "follower bit held after edge",
            data_out_s, exp_bit({32'h0, IMG_S}, k));
    repeat (2 + $urandom % 3) @(negedge clk);
    sin_s = 1'b0;
    repeat (4 + $urandom % 3) @(negedge clk);
  endtask

  initial begin
    int got, biv, highs;
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    oe_m = 1'b0; cs_m = 1'b1; sin_m = 1'b0;
    oe_s = 1'b0; cs_s = 1'b1; sin_s = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    check(done_m == 1'b0, "R9", "done after reset", done_m, 0);
    check(data_oe_m == 1'b0, "R7", "data released after reset", data_oe_m, 0);
    check(sclk_oe_m && !sclk_out_m, "R5", "master clock low in reset", sclk_out_m, 0);
    check(sclk_oe_s && !sclk_out_s, "R5", "follower clock driven low in reset", sclk_oe_s, 1);
    check(data_oe_s == 1'b0, "R7", "follower data released", data_oe_s, 0);

    // oe low with chip select active: oscillator stopped, data released
    cs_m = 1'b0;
    count_clk_high(8, highs);
    check(highs == 0, "R5", "clock stays low while oe low", highs, 0);
    check(data_oe_m == 1'b0, "R7", "data released while oe low", data_oe_m, 0);

    // Full stream with random chip-select pauses
    oe_m = 1'b1;
    recv_m(NB_M, 1'b1, "R1", got, biv);
    check(got == NB_M, "R1", "bits received", got, NB_M);
    check(biv == 0, "R11", "oscillator rise spacing errors", biv, 0);
    repeat (2) @(negedge clk);
    check(done_m == 1'b1, "R9", "done after last bit", done_m, 1);

    // Parked pins after completion
    count_clk_high(6, highs);
    check(highs == 0 && sclk_oe_m, "R6", "clock parked low after done", highs, 0);
    check(data_oe_m && data_out_m, "R8", "data parked high", {data_oe_m, data_out_m}, 3);
    cs_m = 1'b1;
    #1;
    check(!data_oe_m, "R7", "data released on cs high after done", data_oe_m, 0);
    repeat (3) @(negedge clk);
    check(done_m == 1'b1, "R9", "done sticky with cs high", done_m, 1);
    cs_m = 1'b0;

    // oe low clears; restart at bit 0
    oe_m = 1'b0;
    @(negedge clk);
    check(done_m == 1'b0, "R4", "done cleared by oe low", done_m, 0);
    count_clk_high(6, highs);
    check(highs == 0, "R5", "clock low after oe drop", highs, 0);
    oe_m = 1'b1;
    recv_m(12, 1'b0, "R4", got, biv);
    check(got == 12, "R4", "restart prefix length", got, 12);

    // Drop oe mid-stream, then a full restart
    @(negedge clk);
    oe_m = 1'b0;
    #1;
    check(!sclk_out_m && sclk_oe_m, "R5", "clock forced low mid-stream", sclk_out_m, 0);
    repeat (3) @(negedge clk);
    check(done_m == 1'b0, "R4", "no done after mid-stream abort", done_m, 0);
    oe_m = 1'b1;
    recv_m(NB_M, 1'b1, "R4", got, biv);
    check(got == NB_M, "R4", "full stream after abort", got, NB_M);
    check(biv == 0, "R11", "rise spacing after abort", biv, 0);

    // Follower device
    oe_s = 1'b1; cs_s = 1'b0;
    repeat (2) @(negedge clk);
    check(sclk_oe_s == 1'b0, "R10", "follower clock pin released", sclk_oe_s, 0);
    check(data_oe_s == 1'b1, "R7", "follower data driven when selected", data_oe_s, 1);
    for (int k = 0; k < NB_S; k++) begin
      if (k == 10) begin
        cs_s = 1'b1;
        #1;
        check(!data_oe_s, "R7", "follower data released on cs high", data_oe_s, 0);
        for (int p = 0; p < 3; p++) pulse_s(k, 1'b0);
        cs_s = 1'b0;
        #1;
        check(data_out_s == exp_bit({32'h0, IMG_S}, k), "R3", "edges ignored while deselected",
              data_out_s, exp_bit({32'h0, IMG_S}, k));
      end
      check(data_oe_s && data_out_s == exp_bit({32'h0, IMG_S}, k), "R10",
            $sformatf("follower bit %0d", k), data_out_s, exp_bit({32'h0, IMG_S}, k));
      pulse_s(k, (k % 5) == 0);
    end
    check(done_s == 1'b1, "R9", "follower done", done_s, 1);
    check(sclk_oe_s && !sclk_out_s, "R6", "follower clock driven low after done", sclk_oe_s, 1);
    check(!data_oe_s, "R8", "follower data released after done", data_oe_s, 0);
    pulse_s(0, 1'b0);
    pulse_s(0, 1'b0);
    check(done_s && !data_oe_s, "R3", "extra edges after done ignored", {done_s, data_oe_s}, 2);
    oe_s = 1'b0;
    @(negedge clk);
    check(done_s == 1'b0 && sclk_oe_s, "R4", "follower cleared by oe low", done_s, 0);

    wrap_up();
  end
endmodule